// File: doc/BRIEF.md
# SPI Master with Select-to-Clock Lead Timer

This block is a single-word SPI master for a host that wants one parallel word shifted out and one shifted in per request. The host drives a start strobe together with a transmit word. The block lowers an active-low chip select, waits a fixed lead time and then generates the serial clock. It shifts the word out most significant bit first while it collects the reply, and it reports completion with a one-cycle done pulse. A busy level covers the whole transaction.

Word width, clock idle level, sampling edge, serial clock half-period and lead time are all build-time parameters. The sampling edge is chosen by absolute direction, rising or falling, and not by leading or trailing edge. Conventional mode 0 is polarity 0 with phase 0. Conventional mode 1 is polarity 0 with phase 1. Conventional mode 3 is polarity 1 with phase 0. Two further build options remove the receive path, giving a write-only master, or the transmit path, giving a read-only master. Each option removes its shift register along with its pin.

Top module: `spi_lead_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` sits at the CPOL level (0 or 1), and `done`, `busy` and `rx_word` are all 0.
- R2: A `start` seen while idle is accepted. From the following cycle until completion, `cs_n` is 0 and `busy` is 1.
- R3: The first `sclk` transition comes exactly LEAD_CYCLES + HALF_PERIOD system cycles after the clock edge that accepted `start`, which is also the edge where `cs_n` falls.
- R4: A transaction makes exactly 2*WIDTH `sclk` transitions, HALF_PERIOD cycles apart. It ends at the idle level, and `sclk` is at the idle level whenever `cs_n` is 1.
- R5: With PHASE 0 the master samples `miso` on rising `sclk` edges and `mosi` changes only on falling edges. With PHASE 1 the edges swap. `mosi` never changes in the cycle where `sclk` moves to the sampling level.
- R6: `tx_word` goes out on `mosi` most significant bit first, one bit per sampling edge.
- R7: The received word is assembled most significant bit first from `miso`, with the first sampled bit ending up in bit WIDTH-1.
- R8: HALF_PERIOD cycles after the last `sclk` transition, `done` pulses for exactly one cycle. In that same cycle `cs_n` returns to 1, `busy` returns to 0 and `rx_word` shows the new word. Acceptance to `done` takes LEAD_CYCLES + (2*WIDTH+1)*HALF_PERIOD cycles, and `rx_word` then holds until the next completion.
- R9: A `start` that arrives while `busy` is 1 has no effect. It changes neither the word in flight nor the completion time, and it does not lead to a second transaction.
- R10: With HAS_MISO = 0, `miso` is ignored and `rx_word` stays 0.
- R11: With HAS_MOSI = 0, `mosi` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one transaction (accepted only when idle) |
| tx_word | input | WIDTH | Word to transmit, captured on acceptance |
| busy | output | 1 | High while a transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | WIDTH | Last received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds three copies of the master. The first is an 8-bit full-duplex master in conventional mode 3 (polarity 1, phase 0), with a half-period of 2 and a lead of 3, so its first edge is a shifting edge. The second is a 12-bit write-only master with polarity 1 and phase 1, at the minimum half-period and lead of 1, so its first edge is a sampling edge with edges every cycle. The third is an 8-bit read-only master with polarity 0, phase 1, a half-period of 3 and a lead of 2. Together they cover both idle levels, both sampling edges, both first-edge orders and both path-removal options, and they give distinct lead and completion times to measure against the formulas.

// File: rtl/spi_lead_pkg.sv
package spi_lead_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_XFER = 2'd2,
    ST_TAIL = 2'd3
  } xfer_state_t;

  // Counter width able to hold values 0..n-1, never below one bit.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/spi_lead_ctrl.sv
module spi_lead_ctrl
  import spi_lead_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int CPOL        = 0,
  parameter int PHASE       = 0,
  parameter int HALF_PERIOD = 2,
  parameter int LEAD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic sample_o,
  output logic shift_o,
  output logic finish_o,
  output logic sclk_o,
  output logic cs_n_o,
  output logic busy_o,
  output logic done_o
);

  localparam int   EDGES      = 2 * WIDTH;
  localparam int   EW         = cnt_width(EDGES);
  localparam int   DW         = cnt_width(HALF_PERIOD);
  localparam int   LW         = cnt_width(LEAD_CYCLES);
  localparam logic IDLE_LVL   = (CPOL != 0);
  localparam logic SAMPLE_LVL = (PHASE == 0);

  xfer_state_t   state;
  logic [LW-1:0] lead_cnt;
  logic [DW-1:0] div_cnt;
  logic [EW-1:0] edge_cnt;
  logic          sclk_q;
  logic          cs_n_q;
  logic          busy_q;
  logic          done_q;

  logic accept;
  logic tick;
  logic lead_last;
  logic edge_last;
  logic into_sample;

  always_comb begin
    accept      = (state == ST_IDLE) && start_i;
    tick        = (div_cnt == DW'(HALF_PERIOD - 1));
    lead_last   = (lead_cnt == LW'(LEAD_CYCLES - 1));
    edge_last   = (edge_cnt == EW'(EDGES - 1));
    into_sample = ((~sclk_q) == SAMPLE_LVL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      lead_cnt <= '0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      sclk_q   <= IDLE_LVL;
      cs_n_q   <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_LEAD;
            cs_n_q   <= 1'b0;
            busy_q   <= 1'b1;
            lead_cnt <= '0;
          end
        end
        ST_LEAD: begin
          if (lead_last) begin
            state    <= ST_XFER;
            div_cnt  <= '0;
            edge_cnt <= '0;
          end else begin
            lead_cnt <= lead_cnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (tick) begin
            div_cnt  <= '0;
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (edge_last) begin
              state <= ST_TAIL;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            div_cnt <= '0;
            state   <= ST_IDLE;
            cs_n_q  <= 1'b1;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    load_o   = accept;
    sample_o = (state == ST_XFER) && tick && into_sample;
    shift_o  = (state == ST_XFER) && tick && !into_sample;
    finish_o = (state == ST_TAIL) && tick;
    sclk_o   = sclk_q;
    cs_n_o   = cs_n_q;
    busy_o   = busy_q;
    done_o   = done_q;
  end

endmodule

// File: rtl/spi_lead_txpath.sv
module spi_lead_txpath #(
  parameter int WIDTH    = 8,
  parameter bit HAS_MOSI = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             sample_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             mosi_o
);

  generate
    if (HAS_MOSI) begin : g_tx
      logic [WIDTH-1:0] sreg;
      logic             seen_sample;

      // The output only advances on a shifting edge once a bit has been
      // sampled, so a leading shifting edge keeps the MSB on the line.
      always_ff @(posedge clk) begin
        if (rst) begin
          sreg        <= '0;
          seen_sample <= 1'b0;
        end else if (load_i) begin
          sreg        <= word_i;
          seen_sample <= 1'b0;
        end else begin
          if (sample_i) begin
            seen_sample <= 1'b1;
          end
          if (shift_i && seen_sample) begin
            sreg <= {sreg[WIDTH-2:0], 1'b0};
          end
        end
      end

      assign mosi_o = sreg[WIDTH-1];
    end else begin : g_no_tx
      assign mosi_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/spi_lead_rxpath.sv
module spi_lead_rxpath #(
  parameter int WIDTH    = 8,
  parameter bit HAS_MISO = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_i,
  input  logic             finish_i,
  input  logic             miso_i,
  output logic [WIDTH-1:0] word_o
);

  generate
    if (HAS_MISO) begin : g_rx
      logic [WIDTH-1:0] sreg;
      logic [WIDTH-1:0] hold;

      always_ff @(posedge clk) begin
        if (rst) begin
          sreg <= '0;
          hold <= '0;
        end else begin
          if (sample_i) begin
            sreg <= {sreg[WIDTH-2:0], miso_i};
          end
          if (finish_i) begin
            hold <= sreg;
          end
        end
      end

      assign word_o = hold;
    end else begin : g_no_rx
      assign word_o = '0;
    end
  endgenerate

endmodule

// File: rtl/spi_lead_master.sv
module spi_lead_master #(
  parameter int WIDTH       = 8,
  parameter int CPOL        = 0,
  parameter int PHASE       = 0,
  parameter int HALF_PERIOD = 2,
  parameter int LEAD_CYCLES = 4,
  parameter bit HAS_MISO    = 1'b1,
  parameter bit HAS_MOSI    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] tx_word,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] rx_word,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);

  logic load;
  logic sample;
  logic shift;
  logic finish;

  spi_lead_ctrl #(
    .WIDTH      (WIDTH),
    .CPOL       (CPOL),
    .PHASE      (PHASE),
    .HALF_PERIOD(HALF_PERIOD),
    .LEAD_CYCLES(LEAD_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .load_o  (load),
    .sample_o(sample),
    .shift_o (shift),
    .finish_o(finish),
    .sclk_o  (sclk),
    .cs_n_o  (cs_n),
    .busy_o  (busy),
    .done_o  (done)
  );

  spi_lead_txpath #(
    .WIDTH   (WIDTH),
    .HAS_MOSI(HAS_MOSI)
  ) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .sample_i(sample),
    .shift_i (shift),
    .word_i  (tx_word),
    .mosi_o  (mosi)
  );

  spi_lead_rxpath #(
    .WIDTH   (WIDTH),
    .HAS_MISO(HAS_MISO)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .sample_i(sample),
    .finish_i(finish),
    .miso_i  (miso),
    .word_o  (rx_word)
  );

endmodule

// File: rtl/spi_lead_checker.sv
module spi_lead_checker #(
  parameter int WIDTH       = 8,
  parameter int CPOL        = 0,
  parameter int PHASE       = 0,
  parameter bit HAS_MISO    = 1'b1,
  parameter bit HAS_MOSI    = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] rx_word,
  input logic             sclk,
  input logic             mosi,
  input logic             cs_n
);

  localparam logic IDLE_LVL   = (CPOL != 0);
  localparam logic SAMPLE_LVL = (PHASE == 0);

  AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (sclk == IDLE_LVL)) else $error("idle clock level"); // R4

  AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !cs_n)) else $error("start not accepted"); // R2

  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cs_n) else $error("select dropped while busy"); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R8

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !busy)) else $error("done without release"); // R8

  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (rst)
    ((sclk != $past(sclk)) && (sclk == SAMPLE_LVL)) |-> $stable(mosi))
    else $error("mosi moved on sampling edge"); // R5

  generate
    if (!HAS_MOSI) begin : g_no_mosi
      AST_MOSI_ZERO: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mosi) else $error("mosi driven without tx path"); // R11
    end
    if (!HAS_MISO) begin : g_no_miso
      AST_RX_ZERO: assert property (@(posedge clk) disable iff (rst)
        done |-> (rx_word == '0)) else $error("rx word without rx path"); // R10
    end
  endgenerate

endmodule

bind spi_lead_master spi_lead_checker #(
  .WIDTH   (WIDTH),
  .CPOL    (CPOL),
  .PHASE   (PHASE),
  .HAS_MISO(HAS_MISO),
  .HAS_MOSI(HAS_MOSI)
) u_checker (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .rx_word(rx_word),
  .sclk   (sclk),
  .mosi   (mosi),
  .cs_n   (cs_n)
);

// File: tb/test_spi_lead_master.sv
`timescale 1ns / 1ps

module spi_bench_slave #(
  parameter int W           = 8,
  parameter bit SAMPLE_RISE = 1'b1
) (
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         mosi,
  input  logic [W-1:0] load_word,
  output logic         miso,
  output logic [W-1:0] got
);
  logic [W-1:0] sreg = '0;
  int           nsamp = 0;

  initial got = '0;
  assign miso = sreg[W-1];

  always @(negedge cs_n) begin
    sreg  = load_word;
    nsamp = 0;
  end

  always @(sclk) begin
    if (cs_n === 1'b0) begin
      if (sclk === SAMPLE_RISE) begin
        got   = {got[W-2:0], mosi};
        nsamp = nsamp + 1;
      end else if (nsamp > 0) begin
        sreg = {sreg[W-2:0], 1'b0};
      end
    end
  end
endmodule

module test_spi_lead_master;

  localparam int W_P[3]    = '{8, 12, 8};
  localparam int CPOL_P[3] = '{1, 1, 0};
  localparam int HALF_P[3] = '{2, 1, 3};
  localparam int LEAD_P[3] = '{3, 1, 2};
  localparam bit SLV_P[3]  = '{1'b1, 1'b0, 1'b0};

  localparam int NV = 8;
  localparam int          VU[NV]   = '{0, 0, 0, 0, 1, 1, 2, 2};
  localparam logic [15:0] VTX[NV]  = '{16'h00A5, 16'h0000, 16'h00FF, 16'h0081,
                                       16'h0ABC, 16'h0801, 16'h005A, 16'h00FF};
  localparam logic [15:0] VSTX[NV] = '{16'h003C, 16'h00FF, 16'h0000, 16'h007E,
                                       16'h00FF, 16'h0555, 16'h00C3, 16'h0001};
  localparam logic [15:0] VRX[NV]  = '{16'h003C, 16'h00FF, 16'h0000, 16'h007E,
                                       16'h0000, 16'h0000, 16'h00C3, 16'h0001};
  localparam logic [15:0] VSL[NV]  = '{16'h00A5, 16'h0000, 16'h00FF, 16'h0081,
                                       16'h0ABC, 16'h0801, 16'h0000, 16'h0000};

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst;

  logic        start_v[3];
  logic [15:0] tx_v[3];
  logic [15:0] sl_load[3];
  wire         cs_v[3];
  wire         sclk_v[3];
  wire         mosi_v[3];
  wire         miso_v[3];
  wire         done_v[3];
  wire         busy_v[3];
  wire [7:0]   rx0;
  wire [11:0]  rx1;
  wire [7:0]   rx2;
  wire [7:0]   got0;
  wire [11:0]  got1;
  wire [7:0]   got2;
  wire [15:0]  rx_v[3];
  wire [15:0]  got_v[3];

  assign rx_v[0]  = {8'h00, rx0};
  assign rx_v[1]  = {4'h0, rx1};
  assign rx_v[2]  = {8'h00, rx2};
  assign got_v[0] = {8'h00, got0};
  assign got_v[1] = {4'h0, got1};
  assign got_v[2] = {8'h00, got2};

  spi_lead_master #(.WIDTH(8), .CPOL(1), .PHASE(0), .HALF_PERIOD(2), .LEAD_CYCLES(3),
                    .HAS_MISO(1'b1), .HAS_MOSI(1'b1)) i_spi_lead_master (
    .clk(clk), .rst(rst), .start(start_v[0]), .tx_word(tx_v[0][7:0]),
    .busy(busy_v[0]), .done(done_v[0]), .rx_word(rx0), .sclk(sclk_v[0]),
    .mosi(mosi_v[0]), .miso(miso_v[0]), .cs_n(cs_v[0]));

  spi_lead_master #(.WIDTH(12), .CPOL(1), .PHASE(1), .HALF_PERIOD(1), .LEAD_CYCLES(1),
                    .HAS_MISO(1'b0), .HAS_MOSI(1'b1)) i_spi_lead_master_wo (
    .clk(clk), .rst(rst), .start(start_v[1]), .tx_word(tx_v[1][11:0]),
    .busy(busy_v[1]), .done(done_v[1]), .rx_word(rx1), .sclk(sclk_v[1]),
    .mosi(mosi_v[1]), .miso(miso_v[1]), .cs_n(cs_v[1]));

  spi_lead_master #(.WIDTH(8), .CPOL(0), .PHASE(1), .HALF_PERIOD(3), .LEAD_CYCLES(2),
                    .HAS_MISO(1'b1), .HAS_MOSI(1'b0)) i_spi_lead_master_ro (
    .clk(clk), .rst(rst), .start(start_v[2]), .tx_word(tx_v[2][7:0]),
    .busy(busy_v[2]), .done(done_v[2]), .rx_word(rx2), .sclk(sclk_v[2]),
    .mosi(mosi_v[2]), .miso(miso_v[2]), .cs_n(cs_v[2]));

  spi_bench_slave #(.W(8), .SAMPLE_RISE(1'b1)) i_slave0 (
    .sclk(sclk_v[0]), .cs_n(cs_v[0]), .mosi(mosi_v[0]), .load_word(sl_load[0][7:0]),
    .miso(miso_v[0]), .got(got0));
  spi_bench_slave #(.W(12), .SAMPLE_RISE(1'b0)) i_slave1 (
    .sclk(sclk_v[1]), .cs_n(cs_v[1]), .mosi(mosi_v[1]), .load_word(sl_load[1][11:0]),
    .miso(miso_v[1]), .got(got1));
  spi_bench_slave #(.W(8), .SAMPLE_RISE(1'b0)) i_slave2 (
    .sclk(sclk_v[2]), .cs_n(cs_v[2]), .mosi(mosi_v[2]), .load_word(sl_load[2][7:0]),
    .miso(miso_v[2]), .got(got2));

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input int u, input logic [15:0] tx, input logic [15:0] stx,
                          input bit poke, input logic [15:0] exp_rx,
                          input logic [15:0] exp_sl);
    int   k;
    int   t_first;
    int   t_done;
    int   edges;
    int   dones;
    bit   phase_ok;
    bit   mosi_zero;
    logic last_sclk;
    logic last_mosi;
    logic [15:0] rx_at_done;
    tx_v[u]    = tx;
    sl_load[u] = stx;
    @(negedge clk);
    start_v[u] = 1'b1;
    @(negedge clk);
    start_v[u] = 1'b0;
    // R2: one edge after acceptance
    chk(cs_v[u] == 1'b0 && busy_v[u] == 1'b1, "R2", "select/busy after accept",
        {cs_v[u], busy_v[u]}, 2'b01);
    last_sclk = sclk_v[u];
    last_mosi = mosi_v[u];
    t_first = -1; t_done = -1; edges = 0; dones = 0;
    phase_ok = 1'b1; mosi_zero = (mosi_v[u] === 1'b0);
    rx_at_done = '0;
    k = 1;
    while (t_done < 0 && k < 2000) begin
      @(negedge clk);
      k++;
      if (poke) begin
        start_v[u] = (k == LEAD_P[u] + 3);
        if (k == LEAD_P[u] + 3) tx_v[u] = ~tx;
      end
      if (sclk_v[u] !== last_sclk) begin
        edges++;
        if (t_first < 0) t_first = k - 1;
        if (sclk_v[u] === SLV_P[u] && mosi_v[u] !== last_mosi) phase_ok = 1'b0;
      end
      if (mosi_v[u] !== 1'b0) mosi_zero = 1'b0;
      if (done_v[u] === 1'b1) begin
        t_done = k - 1;
        dones++;
        rx_at_done = rx_v[u];
        chk(cs_v[u] == 1'b1 && busy_v[u] == 1'b0 && sclk_v[u] == CPOL_P[u][0], "R8",
            "release at done", {cs_v[u], busy_v[u], sclk_v[u]}, {2'b10, CPOL_P[u][0]});
      end
      last_sclk = sclk_v[u];
      last_mosi = mosi_v[u];
    end
    start_v[u] = 1'b0;
    chk(t_first == LEAD_P[u] + HALF_P[u], "R3", "cycles to first sclk edge",
        t_first, LEAD_P[u] + HALF_P[u]);
    chk(edges == 2 * W_P[u], "R4", "sclk transition count", edges, 2 * W_P[u]);
    chk(t_done == LEAD_P[u] + (2 * W_P[u] + 1) * HALF_P[u], "R8", "cycles to done",
        t_done, LEAD_P[u] + (2 * W_P[u] + 1) * HALF_P[u]);
    chk(phase_ok, "R5", "mosi stable at sampling edges", phase_ok, 1);
    chk(got_v[u] == exp_sl, (u == 2) ? "R11" : "R6", "word seen by slave",
        got_v[u], exp_sl);
    chk(rx_at_done == exp_rx, (u == 1) ? "R10" : "R7", "rx_word at done",
        rx_at_done, exp_rx);
    if (u == 2) chk(mosi_zero, "R11", "mosi held low", mosi_zero, 1);
    @(negedge clk);
    chk(done_v[u] == 1'b0 && dones == 1, "R8", "done single pulse", done_v[u], 0);
    chk(rx_v[u] == rx_at_done, "R8", "rx_word holds after done", rx_v[u], rx_at_done);
    if (poke) begin
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        if (cs_v[u] !== 1'b1) begin
          chk(1'b0, "R9", "second transaction started", cs_v[u], 1);
          break;
        end
      end
      chk(cs_v[u] == 1'b1 && busy_v[u] == 1'b0, "R9", "idle after ignored start",
          {cs_v[u], busy_v[u]}, 2'b10);
      tx_v[u] = tx;
    end
  endtask

  initial begin
    for (int u = 0; u < 3; u++) begin
      start_v[u] = 1'b0;
      tx_v[u]    = '0;
      sl_load[u] = '0;
    end
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state on every build
    for (int u = 0; u < 3; u++) begin
      chk(cs_v[u] == 1'b1, "R1", "cs_n after reset", cs_v[u], 1);
      chk(sclk_v[u] == CPOL_P[u][0], "R1", "sclk idle after reset", sclk_v[u], CPOL_P[u]);
      chk(done_v[u] == 1'b0 && busy_v[u] == 1'b0, "R1", "done/busy after reset",
          {done_v[u], busy_v[u]}, 0);
      chk(rx_v[u] == 16'h0, "R1", "rx_word after reset", rx_v[u], 0);
    end
    // Table walk: R2..R8, R10, R11 on all three builds
    for (int i = 0; i < NV; i++) begin
      run_xfer(VU[i], VTX[i], VSTX[i], 1'b0, VRX[i], VSL[i]);
    end
    // R9: start during busy with a different word is ignored
    run_xfer(0, 16'h00C6, 16'h0093, 1'b1, 16'h0093, 16'h00C6);
    // R7 boundary: single high bit at each end, back to back
    run_xfer(0, 16'h0001, 16'h0080, 1'b0, 16'h0080, 16'h0001);
    run_xfer(2, 16'h0000, 16'h0080, 1'b0, 16'h0080, 16'h0000);
    // R10: miso toggling on write-only build leaves rx_word at zero
    run_xfer(1, 16'h0FFF, 16'h0AAA, 1'b1, 16'h0000, 16'h0FFF);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule